// File: doc/BRIEF.md
# Receive Task Sequencer for a Four-Level Symbol Modem

This block runs the receive-side tasks of a four-level FSK modem under the control of a host. The host writes a task code. The block then takes a fixed number of 2-bit symbols from the demodulator stream. It separates out the synchronisation symbols embedded at fixed places in the stream and packs the remaining payload symbols into a small byte buffer that the host reads. When the task finishes, the block raises the buffer-free and interrupt flags. The host may then read the buffer and issue the next task.

Four tasks exist. Two are 69-symbol block tasks: header, and intermediate/last. The others are a raw four-symbol byte read and a 24-symbol station-identity read. Each sync symbol is reported part-way through a task: its value goes to the sync-value field and the sync-ready flag is raised. An optional interrupt comes with it. Forward-error decoding, de-interleaving and CRC arithmetic live outside this block. A stub stands in for them: payload symbols are packed four to a byte, and the CRC verdict arrives on the `crc_ok` input.

The symbol input is a valid/ready stream. `sym_ready` is held high at all times, so the block never applies back-pressure. A symbol counts as transferred on every clock edge where `sym_valid` is high. Symbols that arrive with no task running are accepted and discarded.

Top module: `fsk_rx_task_seq`

## Requirements
- R1: After reset, `buf_free`=1, `irq`=0, `sync_rdy`=0, `sync_val`=0 and `crc_err`=0.
- R2: A cycle with `cmd_valid`=1 starts the task named by `cmd_code`, which is 0 for header, 1 for intermediate/last, 2 for four-symbol and 3 for station-ID. On the next edge it clears `buf_free`. A command given while a task runs restarts the symbol count from zero.
- R3: Header and intermediate/last tasks consume exactly 69 symbols. The symbols at indices 22, 45 and 68 (counted from 0) are sync symbols and are not payload. The edge that takes symbol 68 sets `buf_free` and `irq`.
- R4: Payload symbols are packed four to a byte. The earliest symbol of a byte goes in bits [7:6] and the latest in bits [1:0]. Bytes are written from buffer address 0 upward. A block task writes 12 bytes (for a header, 10 data bytes then 2 CRC bytes) from its first 48 payload symbols. Later payload symbols are dropped.
- R5: Each sync symbol loads its value into `sync_val` and sets `sync_rdy`. It also sets `irq` only when `sync_irq_en`=1.
- R6: The third sync symbol of a block sets `sync_rdy` on the same edge that sets `buf_free`.
- R7: At completion of header, intermediate/last and station-ID tasks, `crc_err` takes the inverse of `crc_ok`. The four-symbol task leaves `crc_err` unchanged.
- R8: The four-symbol task takes 4 symbols, writes one byte to address 0 and then sets `buf_free` and `irq`.
- R9: The station-ID task takes 23 payload symbols followed by one sync symbol at index 23. It writes 3 bytes from its first 12 payload symbols. It then sets `buf_free`, `sync_rdy` and `irq` and loads `sync_val`.
- R10: A cycle with `status_rd`=1 clears `irq` and `sync_rdy`. If a set happens on the same edge, the set wins.
- R11: `sym_ready` is always 1. Symbols that arrive while no task runs, or in the same cycle as `cmd_valid`, change no flag and no buffer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host writes a task code this cycle |
| cmd_code | input | 2 | Task code (0 header, 1 inter/last, 2 four-symbol, 3 station-ID) |
| sync_irq_en | input | 1 | Mode bit: sync symbols also raise the interrupt |
| crc_ok | input | 1 | CRC verdict from the external decoder stub |
| status_rd | input | 1 | Host reads status; clears interrupt and sync-ready |
| sym_valid | input | 1 | Received symbol present |
| sym_ready | output | 1 | Symbol accepted (always high) |
| sym_data | input | 2 | Received 2-bit symbol |
| buf_rd_addr | input | 4 | Byte buffer read address |
| buf_rd_data | output | 8 | Byte at `buf_rd_addr` (0 beyond depth) |
| buf_free | output | 1 | Task done; buffer may be read |
| irq | output | 1 | Interrupt flag |
| sync_rdy | output | 1 | A sync symbol has arrived since the last status read |
| sync_val | output | 2 | Value of the latest sync symbol |
| crc_err | output | 1 | CRC failure of the last checked task |

## Verification
The hardest case to reach is the one where the third sync symbol and the end of the task land on the same edge. It can only be seen apart from the earlier syncs if `sync_rdy` was already cleared before symbol 68. The stimulus therefore adds a status-read cycle after symbol 45. It then confirms that both flags are low just before the final symbol and both high just after it. A second hard case is a status read that coincides with a sync symbol. The stimulus asserts `status_rd` in the same cycle as symbol 22 to show that the set takes priority.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;
  typedef enum logic [1:0] {
    TASK_HDR  = 2'd0,
    TASK_BLK  = 2'd1,
    TASK_QUAD = 2'd2,
    TASK_SID  = 2'd3
  } rx_task_e;
endpackage

// File: rtl/fsk_rx_ctrl.sv
module fsk_rx_ctrl
  import fsk_rx_pkg::*;
#(
  parameter int NUM_SYNC  = 3,
  parameter int SYNC_GAP  = 23,
  parameter int SID_SYMS  = 24,
  parameter int QUAD_SYMS = 4,
  parameter int BUF_BYTES = 12,
  parameter int SID_BYTES = 3,
  localparam int BLK_SYMS = NUM_SYNC * SYNC_GAP,
  localparam int CNT_W    = $clog2(BLK_SYMS + 1),
  localparam int LIM_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  input  logic             sym_valid,
  output logic             start_stb,
  output logic             pay_stb,
  output logic             sync_stb,
  output logic             done_stb,
  output rx_task_e         task_q,
  output logic [LIM_W-1:0] byte_lim
);
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] task_len;
  logic             at_sync;
  logic             accept;

  always_comb begin
    unique case (task_q)
      TASK_QUAD: begin task_len = CNT_W'(QUAD_SYMS); byte_lim = LIM_W'(1);         end
      TASK_SID:  begin task_len = CNT_W'(SID_SYMS);  byte_lim = LIM_W'(SID_BYTES); end
      default:   begin task_len = CNT_W'(BLK_SYMS);  byte_lim = LIM_W'(BUF_BYTES); end
    endcase
  end

  always_comb begin
    at_sync = 1'b0;
    if (task_q == TASK_HDR || task_q == TASK_BLK) begin
      for (int k = 1; k <= NUM_SYNC; k++)
        if (cnt == CNT_W'(k * SYNC_GAP - 1)) at_sync = 1'b1;
    end else if (task_q == TASK_SID) begin
      at_sync = (cnt == CNT_W'(SID_SYMS - 1));
    end
  end

  assign accept    = sym_valid && active && !cmd_valid;
  assign start_stb = cmd_valid;
  assign sync_stb  = accept && at_sync;
  assign pay_stb   = accept && !at_sync;
  assign done_stb  = accept && (cnt == task_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      task_q <= TASK_HDR;
    end else if (cmd_valid) begin
      active <= 1'b1;
      cnt    <= '0;
      task_q <= rx_task_e'(cmd_code);
    end else if (accept) begin
      cnt <= cnt + CNT_W'(1);
      if (done_stb) active <= 1'b0;
    end
  end
endmodule

// File: rtl/fsk_rx_packer.sv
module fsk_rx_packer #(
  parameter int SYM_W     = 2,
  parameter int BYTE_W    = 8,
  parameter int BUF_BYTES = 12,
  localparam int PER_BYTE = BYTE_W / SYM_W,
  localparam int POS_W    = $clog2(PER_BYTE),
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int LIM_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pay_stb,
  input  logic [SYM_W-1:0]  sym,
  input  logic [LIM_W-1:0]  byte_lim,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  logic [BYTE_W-SYM_W-1:0] acc;
  logic [POS_W-1:0]        pos;
  logic [LIM_W-1:0]        idx;
  logic                    room;

  assign room    = idx < byte_lim;
  assign wr_data = {acc, sym};
  assign wr_addr = ADDR_W'(idx);
  assign wr_en   = pay_stb && room && (pos == POS_W'(PER_BYTE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      pos <= '0;
      idx <= '0;
    end else if (start) begin
      acc <= '0;
      pos <= '0;
      idx <= '0;
    end else if (pay_stb && room) begin
      acc <= {acc[BYTE_W-2*SYM_W-1:0], sym};
      pos <= pos + POS_W'(1);
      if (wr_en) idx <= idx + LIM_W'(1);
    end
  end
endmodule

// File: rtl/fsk_rx_buf.sv
module fsk_rx_buf #(
  parameter int DEPTH  = 12,
  parameter int BYTE_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     mem[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))        mem[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < DEPTH; k++)
      if (rd_addr == ADDR_W'(k)) rd_data = mem[k];
  end
endmodule

// File: rtl/fsk_rx_status.sv
module fsk_rx_status
  import fsk_rx_pkg::*;
#(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sync_stb,
  input  logic             done_stb,
  input  rx_task_e         task_q,
  input  logic [SYM_W-1:0] sym,
  input  logic             sync_irq_en,
  input  logic             crc_ok,
  input  logic             status_rd,
  output logic             buf_free,
  output logic             irq,
  output logic             sync_rdy,
  output logic [SYM_W-1:0] sync_val,
  output logic             crc_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_free <= 1'b1;
      irq      <= 1'b0;
      sync_rdy <= 1'b0;
      sync_val <= '0;
      crc_err  <= 1'b0;
    end else begin
      if (status_rd) begin
        irq      <= 1'b0;
        sync_rdy <= 1'b0;
      end
      if (start) buf_free <= 1'b0;
      if (sync_stb) begin
        sync_val <= sym;
        sync_rdy <= 1'b1;
        if (sync_irq_en) irq <= 1'b1;
      end
      if (done_stb) begin
        buf_free <= 1'b1;
        irq      <= 1'b1;
        if (task_q != TASK_QUAD) crc_err <= !crc_ok;
      end
    end
  end
endmodule

// File: rtl/fsk_rx_task_seq.sv
module fsk_rx_task_seq
  import fsk_rx_pkg::*;
#(
  parameter int SYM_W     = 2,
  parameter int BYTE_W    = 8,
  parameter int NUM_SYNC  = 3,
  parameter int SYNC_GAP  = 23,
  parameter int SID_SYMS  = 24,
  parameter int QUAD_SYMS = 4,
  parameter int BUF_BYTES = 12,
  parameter int SID_BYTES = 3,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int LIM_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic              sync_irq_en,
  input  logic              crc_ok,
  input  logic              status_rd,
  input  logic              sym_valid,
  output logic              sym_ready,
  input  logic [SYM_W-1:0]  sym_data,
  input  logic [ADDR_W-1:0] buf_rd_addr,
  output logic [BYTE_W-1:0] buf_rd_data,
  output logic              buf_free,
  output logic              irq,
  output logic              sync_rdy,
  output logic [SYM_W-1:0]  sync_val,
  output logic              crc_err
);
  logic              start_stb, pay_stb, sync_stb, done_stb;
  rx_task_e          task_q;
  logic [LIM_W-1:0]  byte_lim;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  assign sym_ready = 1'b1;

  fsk_rx_ctrl #(
    .NUM_SYNC(NUM_SYNC), .SYNC_GAP(SYNC_GAP), .SID_SYMS(SID_SYMS),
    .QUAD_SYMS(QUAD_SYMS), .BUF_BYTES(BUF_BYTES), .SID_BYTES(SID_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sym_valid(sym_valid), .start_stb(start_stb), .pay_stb(pay_stb),
    .sync_stb(sync_stb), .done_stb(done_stb), .task_q(task_q), .byte_lim(byte_lim)
  );

  fsk_rx_packer #(.SYM_W(SYM_W), .BYTE_W(BYTE_W), .BUF_BYTES(BUF_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .start(start_stb), .pay_stb(pay_stb), .sym(sym_data),
    .byte_lim(byte_lim), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fsk_rx_buf #(.DEPTH(BUF_BYTES), .BYTE_W(BYTE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(buf_rd_addr), .rd_data(buf_rd_data)
  );

  fsk_rx_status #(.SYM_W(SYM_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .start(start_stb), .sync_stb(sync_stb),
    .done_stb(done_stb), .task_q(task_q), .sym(sym_data),
    .sync_irq_en(sync_irq_en), .crc_ok(crc_ok), .status_rd(status_rd),
    .buf_free(buf_free), .irq(irq), .sync_rdy(sync_rdy), .sync_val(sync_val),
    .crc_err(crc_err)
  );
endmodule

// File: rtl/fsk_rx_task_seq_chk.sv
module fsk_rx_task_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_code,
  input logic       status_rd,
  input logic       sym_valid,
  input logic       sym_ready,
  input logic       buf_free,
  input logic       irq,
  input logic       sync_rdy,
  input logic [1:0] sync_val,
  input logic       crc_err
);
  logic [1:0] last_cmd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_cmd <= 2'd2;
    else if (cmd_valid) last_cmd <= cmd_code;
  end

  a_r2_cmd_clears_free: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !buf_free);

  a_r3_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_free) |-> irq);

  a_r6_last_sync_with_free: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(buf_free) && last_cmd != 2'd2) |-> sync_rdy);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !sym_valid) |=> (!irq && !sync_rdy));

  a_r11_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready);

  a_r11_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_free && !cmd_valid) |=> ($stable(sync_val) && $stable(crc_err) && buf_free));
endmodule

bind fsk_rx_task_seq fsk_rx_task_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .status_rd(status_rd), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .buf_free(buf_free), .irq(irq), .sync_rdy(sync_rdy), .sync_val(sync_val),
  .crc_err(crc_err)
);

// File: tb/fsk_rx_task_seq_bench.sv
module fsk_rx_task_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic       sync_irq_en = 1'b0;
  logic       crc_ok = 1'b1;
  logic       status_rd = 1'b0;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [1:0] sym_data = 2'd0;
  logic [3:0] buf_rd_addr = 4'd0;
  logic [7:0] buf_rd_data;
  logic       buf_free, irq, sync_rdy, crc_err;
  logic [1:0] sync_val;

  int checks = 0;
  int fails = 0;
  bit exp_crc = 1'b0;

  always #4 clk = ~clk;

  fsk_rx_task_seq u_fsk_rx_task_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sync_irq_en(sync_irq_en), .crc_ok(crc_ok), .status_rd(status_rd),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data), .buf_free(buf_free),
    .irq(irq), .sync_rdy(sync_rdy), .sync_val(sync_val), .crc_err(crc_err)
  );

  // fields: [9:8] task, [7] sync irq enable, [6] crc_ok, [5:3] mul, [2:0] add
  localparam logic [9:0] VEC [6] = '{
    {2'd0, 1'b1, 1'b1, 3'd1, 3'd0},
    {2'd1, 1'b0, 1'b0, 3'd3, 3'd2},
    {2'd2, 1'b0, 1'b1, 3'd1, 3'd1},
    {2'd3, 1'b1, 1'b0, 3'd2, 3'd3},
    {2'd1, 1'b1, 1'b1, 3'd5, 3'd1},
    {2'd0, 1'b0, 1'b0, 3'd7, 3'd6}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_sym(input logic [1:0] s, input logic rd);
    sym_valid = 1'b1; sym_data = s; status_rd = rd;
    @(negedge clk);
    sym_valid = 1'b0; status_rd = 1'b0;
  endtask

  task automatic pulse_rd();
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic start_cmd(input logic [1:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 buf_free cleared by command", buf_free, 0);
  endtask

  task automatic run_task(input logic [1:0] c, input logic ien, input logic ok,
                          input int mul, input int add, input int co_rd, input int gap_rd);
    int len, lim, bi, pos;
    logic [7:0] cur;
    logic [7:0] exb [12];
    logic [1:0] s, last_sync;
    bit is_s;
    len = (c == 2) ? 4 : (c == 3) ? 24 : 69;
    lim = (c == 2) ? 1 : (c == 3) ? 3 : 12;
    bi = 0; pos = 0; cur = 8'd0; last_sync = 2'd0;
    for (int b = 0; b < 12; b++) exb[b] = 8'd0;
    sync_irq_en = ien; crc_ok = ok;
    pulse_rd();
    start_cmd(c);
    for (int i = 0; i < len; i++) begin
      s = 2'(i * mul + add + i / 5);
      is_s = (c < 2) ? (i == 22 || i == 45 || i == 68) : (c == 3 && i == 23);
      if (!is_s && bi < lim) begin
        cur = {cur[5:0], s};
        pos++;
        if (pos == 4) begin exb[bi] = cur; bi++; pos = 0; end
      end
      if (is_s) last_sync = s;
      drive_sym(s, i == co_rd);
      if (i == 22 && c < 2) begin
        check("R5 sync_rdy after sync 22", sync_rdy, 1);
        check("R5 sync_val after sync 22", sync_val, s);
        check("R5 irq follows enable", irq, ien);
        check("R3 still busy mid-block", buf_free, 0);
      end
      if (i == gap_rd) pulse_rd();
      if (i == 67 && gap_rd == 45) begin
        check("R6 free low before last sync", buf_free, 0);
        check("R6 sync_rdy low before last sync", sync_rdy, 0);
      end
    end
    check(c == 2 ? "R8 buf_free at end" : c == 3 ? "R9 buf_free at end" : "R3 buf_free at end", buf_free, 1);
    check(c == 2 ? "R8 irq at end" : c == 3 ? "R9 irq at end" : "R3 irq at end", irq, 1);
    if (c != 2) exp_crc = !ok;
    check("R7 crc_err", crc_err, exp_crc);
    if (c != 2) begin
      check(c == 3 ? "R9 sync_rdy at end" : "R6 sync_rdy with buf_free", sync_rdy, 1);
      check("R5 sync_val of last sync", sync_val, last_sync);
    end
    for (int b = 0; b < lim; b++) begin
      buf_rd_addr = 4'(b);
      #1;
      check("R4 buffer byte", buf_rd_data, exb[b]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 buf_free reset", buf_free, 1);
    check("R1 irq reset", irq, 0);
    check("R1 sync_rdy reset", sync_rdy, 0);
    check("R1 sync_val reset", sync_val, 0);
    check("R1 crc_err reset", crc_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 sym_ready high", sym_ready, 1);

    for (int v = 0; v < 6; v++)
      run_task(VEC[v][9:8], VEC[v][7], VEC[v][6], int'(VEC[v][5:3]), int'(VEC[v][2:0]), -1, -1);

    // third sync coincident with buf_free; read co-asserted with sync 22 (set wins)
    run_task(2'd1, 1'b1, 1'b1, 3, 1, 22, 45);
    check("R10 set wins over read, irq still set", irq, 1);

    // R10 read clears flags
    pulse_rd();
    check("R10 irq cleared by read", irq, 0);
    check("R10 sync_rdy cleared by read", sync_rdy, 0);

    // R11 idle symbols ignored
    buf_rd_addr = 4'd0;
    #1;
    begin
      logic [7:0] b0;
      logic [1:0] sv;
      b0 = buf_rd_data; sv = sync_val;
      for (int i = 0; i < 30; i++) drive_sym(2'(i + 1), 1'b0);
      #1;
      check("R11 idle buffer unchanged", buf_rd_data, b0);
      check("R11 idle sync_val unchanged", sync_val, sv);
      check("R11 idle irq unchanged", irq, 0);
      check("R11 idle sync_rdy unchanged", sync_rdy, 0);
      check("R11 idle buf_free unchanged", buf_free, 1);
    end

    // R2 restart mid-task, and symbol with command is dropped (R11)
    start_cmd(2'd2);
    drive_sym(2'd3, 1'b0);
    drive_sym(2'd3, 1'b0);
    cmd_valid = 1'b1; cmd_code = 2'd2; sym_valid = 1'b1; sym_data = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0; sym_valid = 1'b0;
    drive_sym(2'd0, 1'b0);
    drive_sym(2'd1, 1'b0);
    drive_sym(2'd2, 1'b0);
    check("R2 restarted task not done after 3", buf_free, 0);
    drive_sym(2'd1, 1'b0);
    buf_rd_addr = 4'd0;
    #1;
    check("R2 restart packs fresh byte", buf_rd_data, 8'h19);
    check("R8 quad done", buf_free, 1);
    check("R7 quad keeps crc_err", crc_err, exp_crc);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule